// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds stores that have issued but not yet reached memory. Each entry keeps a target address and either the store value or a nonzero tag naming the unit that will produce that value. While an entry waits, it watches the result broadcast bus. When a broadcast carries its tag, the entry takes the broadcast value and its data becomes valid.

Entries are allocated in issue order and leave in the same order. The oldest entry is written to memory once its data is valid and the memory port accepts it. Every load address is compared against all buffered stores in the same cycle. When a store to the same address is pending, the load takes that store's value instead of the older value held in memory. If the store's value has not been produced yet, the load is told to wait.

The lookup is purely combinational on the current buffer contents. `DEPTH` must be a power of two.

Top module: `store_forward_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_wr_valid` is 0, and no lookup reports hit or wait.
- R2: `st_ready` is 0 exactly when all `DEPTH` (4) entries are occupied. A store offered while `st_ready` is 0 is not accepted and changes nothing.
- R3: A store issued with `st_tag` equal to 0 carries valid data at once. A nonzero `st_tag` marks its data as pending on that tag.
- R4: An occupied entry with a pending tag that equals `bc_tag` while `bc_valid` is 1 takes `bc_data` on that clock edge, and its data becomes valid. Entries whose tags differ keep their contents.
- R5: A store issued with a nonzero tag in the same cycle as a broadcast of that tag is stored with the broadcast value, already valid.
- R6: When `ld_valid` is 1 and an occupied entry's address equals `ld_addr`, and that entry's data is valid, `ld_hit` is 1 and `ld_data` is that entry's value. The check covers every entry in the same cycle.
- R7: When several entries match the load address, the result comes from the most recently issued matching entry.
- R8: If the most recently issued matching entry still has pending data, `ld_wait` is 1 and `ld_hit` is 0. This holds even when older matching entries have valid data.
- R9: With no matching entry, or with `ld_valid` at 0, `ld_hit` and `ld_wait` are 0 and `ld_data` is 0.
- R10: `mem_wr_valid` is 1 exactly when the oldest entry exists and its data is valid, and it presents that entry's address and data. While `mem_wr_ready` is 0 these outputs hold. A transfer with `mem_wr_ready` at 1 frees the entry.
- R11: Memory writes leave in issue order. A younger entry with valid data is never written while an older entry is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store issue request |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store value, used when `st_tag` is 0 |
| st_tag | input | TW | Producer tag of the store value, 0 when the value is present |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load address to compare |
| ld_hit | output | 1 | A buffered store supplies the load value |
| ld_wait | output | 1 | The youngest matching store has no value yet |
| ld_data | output | DW | Forwarded value, 0 when there is no hit |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TW | Tag of the broadcast result |
| bc_data | input | DW | Broadcast result value |
| mem_wr_valid | output | 1 | Oldest store ready for memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |

## Verification
The assertions check properties that hold on every cycle. Hit and wait never occur together. A stalled memory write keeps its address and data. A rejected store leaves the occupancy unchanged unless a write drains. Every entry whose tag is broadcast becomes valid with the broadcast value on the next edge.

Only the bench's scenarios can show the remaining behaviour. These are the choice of the youngest among several matching stores, the wait caused by a pending youngest store that shadows older valid ones, the capture of a broadcast in the same cycle as issue, and strict issue-order draining. The bench compares all of these cycle by cycle against a queue model.

// File: rtl/store_forward_buffer.sv
module store_forward_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [TW-1:0] st_tag,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic          ld_wait,
  output logic [DW-1:0] ld_data,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          busy_q [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [TW-1:0] tag_q  [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  logic push, pop, st_fill;
  logic found;
  logic [PW-1:0] sel;

  assign st_ready     = cnt_q != CW'(DEPTH);
  assign push         = st_valid && st_ready;
  assign mem_wr_valid = busy_q[head_q] && (tag_q[head_q] == '0);
  assign mem_wr_addr  = addr_q[head_q];
  assign mem_wr_data  = data_q[head_q];
  assign pop          = mem_wr_valid && mem_wr_ready;
  assign st_fill      = (st_tag != '0) && bc_valid && (bc_tag == st_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        busy_q[i] <= 1'b0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (busy_q[i] && (tag_q[i] != '0) && bc_valid && (tag_q[i] == bc_tag)) begin
          data_q[i] <= bc_data;
          tag_q[i]  <= '0;
        end
      end
      if (pop) begin
        busy_q[head_q] <= 1'b0;
        head_q         <= head_q + 1'b1;
      end
      if (push) begin
        busy_q[tail_q] <= 1'b1;
        addr_q[tail_q] <= st_addr;
        data_q[tail_q] <= st_fill ? bc_data : st_data;
        tag_q[tail_q]  <= st_fill ? '0 : st_tag;
        tail_q         <= tail_q + 1'b1;
      end
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  // scan oldest to youngest; the last match wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head_q + PW'(k);
      if (busy_q[idx] && (addr_q[idx] == ld_addr)) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end

  assign ld_hit  = ld_valid && found && (tag_q[sel] == '0);
  assign ld_wait = ld_valid && found && (tag_q[sel] != '0);
  assign ld_data = ld_hit ? data_q[sel] : '0;

  assert_hit_wait_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_stall_no_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready && !pop) |=> (cnt_q == $past(cnt_q)));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_snoop_chk
    assert_snoop_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[g] && (tag_q[g] != '0) && bc_valid && (tag_q[g] == bc_tag)) |=>
        ((tag_q[g] == '0) && (data_q[g] == $past(bc_data))));
  end
endmodule

// File: tb/test_store_forward_buffer.sv
module test_store_forward_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [TW-1:0] st_tag = '0;
  logic ld_valid = 0, ld_hit, ld_wait;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data;
  logic bc_valid = 0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic mem_wr_valid, mem_wr_ready = 0;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  store_forward_buffer #(.DEPTH(D), .AW(AW), .DW(DW), .TW(TW)) i_store_forward_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_tag(st_tag),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_wait(ld_wait), .ld_data(ld_data),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] m_addr [D];
  logic [DW-1:0] m_data [D];
  logic [TW-1:0] m_tag  [D];
  int m_head = 0, m_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_lookup(input logic [AW-1:0] a, output bit hit,
                                     output bit wt, output logic [DW-1:0] d);
    int sel = -1;
    hit = 0; wt = 0; d = '0;
    for (int k = 0; k < m_cnt; k++) begin
      int idx = (m_head + k) % D;
      if (m_addr[idx] == a) sel = idx;
    end
    if (sel >= 0) begin
      if (m_tag[sel] == '0) begin hit = 1; d = m_data[sel]; end
      else wt = 1;
    end
  endfunction

  function automatic bit exp_mem();
    return (m_cnt > 0) && (m_tag[m_head] == '0);
  endfunction

  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [TW-1:0] stg, input bit lv, input logic [AW-1:0] la,
                      input bit bv, input logic [TW-1:0] btg, input logic [DW-1:0] bd,
                      input bit mr);
    bit eh, ew, ev, pop, push;
    logic [DW-1:0] ed;
    string lreq;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_tag = stg;
    ld_valid = lv; ld_addr = la;
    bc_valid = bv; bc_tag = btg; bc_data = bd;
    mem_wr_ready = mr;
    #1;
    chk(st_ready == (m_cnt < D), "R2", "st_ready", st_ready, m_cnt < D);
    ev = exp_mem();
    chk(mem_wr_valid == ev, "R10 R11", "mem_wr_valid", mem_wr_valid, ev);
    if (ev) begin
      chk(mem_wr_addr == m_addr[m_head], "R10", "mem_wr_addr", mem_wr_addr, m_addr[m_head]);
      chk(mem_wr_data == m_data[m_head], "R10 R4", "mem_wr_data", mem_wr_data, m_data[m_head]);
    end
    if (lv) exp_lookup(la, eh, ew, ed);
    else begin eh = 0; ew = 0; ed = '0; end
    lreq = ew ? "R8" : (eh ? "R6 R7 R3 R4 R5" : "R9");
    chk(ld_hit == eh, lreq, "ld_hit", ld_hit, eh);
    chk(ld_wait == ew, lreq, "ld_wait", ld_wait, ew);
    chk(ld_data == ed, lreq, "ld_data", ld_data, ed);
    @(posedge clk);
    pop  = ev && mr;
    push = sv && (m_cnt < D);
    // R4 snoop on occupied entries
    for (int k = 0; k < m_cnt; k++) begin
      int idx = (m_head + k) % D;
      if (bv && m_tag[idx] != '0 && m_tag[idx] == btg) begin
        m_data[idx] = bd; m_tag[idx] = '0;
      end
    end
    if (pop) begin m_head = (m_head + 1) % D; m_cnt--; end
    if (push) begin
      int idx = (m_head + m_cnt) % D;
      m_addr[idx] = sa;
      // R3 tag zero means valid, R5 same-cycle capture
      if (stg != '0 && bv && btg == stg) begin m_data[idx] = bd; m_tag[idx] = '0; end
      else begin m_data[idx] = sd; m_tag[idx] = stg; end
      m_cnt++;
    end
  endtask

  function automatic logic [AW-1:0] raddr();
    return 32'h100 + 32'(($urandom % 4) * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the run ended");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    ld_valid = 1; ld_addr = 32'h100;
    #1;
    chk(st_ready == 1'b1, "R1", "st_ready", st_ready, 1);
    chk(mem_wr_valid == 1'b0, "R1", "mem_wr_valid", mem_wr_valid, 0);
    chk(!ld_hit && !ld_wait, "R1", "hit/wait", {ld_hit, ld_wait}, 0);

    // R2 fill with pending stores to one address, then an ignored fifth
    for (int i = 1; i <= 4; i++)
      step(1, 32'h200, 32'h0, TW'(i), 1, 32'h200, 0, '0, '0, 0);
    step(1, 32'h200, 32'hDEAD, '0, 1, 32'h200, 0, '0, '0, 0);
    // R7 R8: older valid, youngest still pending
    step(0, '0, '0, '0, 1, 32'h200, 1, 4'd2, 32'h2222, 1);
    step(0, '0, '0, '0, 1, 32'h200, 1, 4'd4, 32'h4444, 1);
    step(0, '0, '0, '0, 1, 32'h200, 0, '0, '0, 1);
    // R11 head pending blocks valid younger entries
    step(0, '0, '0, '0, 1, 32'h200, 0, '0, '0, 1);
    step(0, '0, '0, '0, 1, 32'h200, 1, 4'd1, 32'h1111, 0);
    // R10 hold while not ready, then drain
    step(0, '0, '0, '0, 0, '0, 1, 4'd3, 32'h3333, 0);
    for (int i = 0; i < 5; i++)
      step(0, '0, '0, '0, 1, 32'h200, 0, '0, '0, 1);
    // R5 issue alongside matching broadcast
    step(1, 32'h300, 32'h0, 4'd5, 1, 32'h300, 1, 4'd5, 32'h5555, 0);
    step(0, '0, '0, '0, 1, 32'h300, 0, '0, '0, 1);
    step(0, '0, '0, '0, 1, 32'h300, 0, '0, '0, 1);

    for (int i = 0; i < 4000; i++)
      step($urandom % 3 != 0, raddr(), $urandom, TW'($urandom % 4),
           $urandom % 4 != 0, raddr(),
           $urandom % 2 == 0, TW'(1 + $urandom % 3), $urandom,
           $urandom % 2 == 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule